// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of general-purpose pins behind a plain 32-bit register port (byte address, write strobe, write data, read data). Every pin has its own configuration bits. In general mode a pin is either an input, whose level can be read, or an output driven from an output-data register. In interrupt mode the pin is an input watched by a detector that raises a per-pin pending flag on an active level or on an edge. The edge may be the rising one, the falling one, or both.

Pin inputs pass through a two-flop synchronizer before anything looks at them. Pending flags collect into one status word. A single interrupt line is the registered OR of the pending flags that are not masked. Edge flags are acknowledged, and pins are masked or unmasked, through write-one-style registers, so software never needs a read-modify-write for them.

Register reads are registered: `rdata` shows the register selected by `addr` one clock after the address is presented. Writes take effect at the clock edge that samples `wr_en`.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high, and after it, every configuration register and the output data are 0, every mask bit is 1 (masked), `pin_oe` is 0, and `irq` and `rdata` are 0.
- R2: A pin with mode bit 0 (general) and direction bit 1 drives `pin_oe`=1 and `pin_out` from its output-data bit. A pin with mode bit 1 (interrupt) never drives `pin_oe`. The offsets are mode 0x00, direction 0x04 and output data 0x08.
- R3: Reading offset 0x0C returns the pin levels two clocks after `pin_in` changes. Writes to 0x0C are ignored.
- R4: In interrupt mode with the edge-select bit (offset 0x24) at 0, the pending bit (offset 0x10) is 1 while the synchronized pin equals the active level. The active level is high when the polarity bit (offset 0x20) is 0 and low when it is 1. Writing the clear register does not remove it while the level persists.
- R5: In interrupt mode with the edge-select bit at 1 and the both-edge bit at 0, a rising edge (polarity 0) or a falling edge (polarity 1) sets the pending bit. The bit stays set after the pin returns, and the opposite edge does not set it.
- R6: With the both-edge bit (offset 0x4C) at 1, an edge-mode pin flags on rising and on falling transitions, whatever its polarity bit is.
- R7: Writing 1 to a bit of the clear register (offset 0x14) clears that pin's edge flag, and a 0 bit has no effect. An edge detected in the same cycle as the clear keeps the flag set.
- R8: Writing 0 to a bit of the mask register (offset 0x18) masks that pin, and a 1 bit leaves it unchanged. Writing 1 to a bit of offset 0x1C unmasks that pin, and a 0 bit leaves it unchanged. Reading 0x18 returns the mask, with 1 meaning masked.
- R9: `irq` is 1 exactly one clock after some pin is both pending and unmasked, and 0 one clock after no such pin exists.
- R10: A pin in general mode never shows a pending bit, whatever its level.
- R11: The polarity register reads back as written. A read of an unmapped offset (for example 0x30) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's `addr` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output-data values to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an edge that lands in the same cycle as an acknowledge write. The detector sits two synchronizer flops and one history flop behind `pin_in`, so the bench changes the pin at a falling clock edge. It then waits exactly one cycle and issues the clear write, so that the write is sampled at the same clock edge that latches the new edge event. A read of the pending word then shows whether the edge survived. The sticky behaviour and the write-zero-has-no-effect rules are checked by reading the pending and mask words back immediately after the writes.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_TRIG   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_DIR, SEL_DOUT, SEL_DIN, SEL_PEND, SEL_ACK,
    SEL_MASK, SEL_UNMASK, SEL_POL, SEL_TRIG, SEL_BOTH
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_MODE:   return SEL_MODE;
      OFS_DIR:    return SEL_DIR;
      OFS_DOUT:   return SEL_DOUT;
      OFS_DIN:    return SEL_DIN;
      OFS_PEND:   return SEL_PEND;
      OFS_ACK:    return SEL_ACK;
      OFS_MASK:   return SEL_MASK;
      OFS_UNMASK: return SEL_UNMASK;
      OFS_POL:    return SEL_POL;
      OFS_TRIG:   return SEL_TRIG;
      OFS_BOTH:   return SEL_BOTH;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] ack,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] ev;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, edge_mode;
      assign rise      = lvl[i] & ~prev_q[i];
      assign fall      = ~lvl[i] & prev_q[i];
      assign edge_mode = mode[i] & trig[i];
      assign ev[i]     = edge_mode & (both[i] ? (rise | fall) : (pol[i] ? fall : rise));

      always_ff @(posedge clk) begin
        if (rst) lat_q[i] <= 1'b0;
        else     lat_q[i] <= (lat_q[i] & ~ack[i] & edge_mode) | ev[i];
      end

      assign pend[i] = mode[i] & (trig[i] ? lat_q[i] : (lvl[i] ^ pol[i]));

      // R7: an acknowledge with no new edge drops the flag
      assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack[i] && !ev[i]) |=> !lat_q[i]);
      // R7: a detected edge is latched even when acknowledged in the same cycle
      assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> lat_q[i]);
    end
  endgenerate
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      din_sync,
  input  logic [W-1:0]      pend,
  output logic [W-1:0]      mode,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      trig,
  output logic [W-1:0]      both,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      ack,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e     sel;
  logic [W-1:0] wbits;

  assign sel   = decode(addr);
  assign wbits = wdata[W-1:0];
  assign ack   = (wr_en && sel == SEL_ACK) ? wbits : '0;

  function automatic logic [DATA_W-1:0] widen(input logic [W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[W-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      dir  <= '0;
      dout <= '0;
      pol  <= '0;
      trig <= '0;
      both <= '0;
      mask <= '1;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE:   mode <= wbits;
        SEL_DIR:    dir  <= wbits;
        SEL_DOUT:   dout <= wbits;
        SEL_POL:    pol  <= wbits;
        SEL_TRIG:   trig <= wbits;
        SEL_BOTH:   both <= wbits;
        SEL_MASK:   mask <= mask | ~wbits;
        SEL_UNMASK: mask <= mask & ~wbits;
        default: ;
      endcase
    end
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode;
      SEL_DIR:  rd_mux = dir;
      SEL_DOUT: rd_mux = dout;
      SEL_DIN:  rd_mux = din_sync;
      SEL_PEND: rd_mux = pend;
      SEL_MASK: rd_mux = mask;
      SEL_POL:  rd_mux = pol;
      SEL_TRIG: rd_mux = trig;
      SEL_BOTH: rd_mux = both;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= widen(rd_mux);
  end

  // R8: bits written as 1 to the unmask offset are unmasked afterwards
  assert_unmask_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_UNMASK) |=> (mask & $past(wbits)) == '0);
  // R8: bits written as 0 to the mask offset are masked afterwards
  assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_MASK) |=> (mask | $past(wbits)) == '1);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] lvl, mode, dir, dout, pol, trig, both, mask, ack, pend;

  gpb_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  gpb_detect #(.W(NPINS)) u_detect (
    .clk(clk), .rst(rst), .lvl(lvl), .mode(mode), .trig(trig),
    .pol(pol), .both(both), .ack(ack), .pend(pend)
  );

  gpb_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .din_sync(lvl), .pend(pend), .mode(mode), .dir(dir), .dout(dout),
    .pol(pol), .trig(trig), .both(both), .mask(mask), .ack(ack),
    .rdata(rdata)
  );

  assign pin_out = dout;
  assign pin_oe  = dir & ~mode;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ~mask);
  end

  // R9: no unmasked pending pin means the request drops next cycle
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~mask) == '0) |=> !irq);
  // R1: reset leaves the request low and no pin driven
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!irq && pin_oe == '0 && rdata == '0));
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic rd_issue = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results from the scoreboard
  always @(posedge clk) begin
    #1;
    if (rd_issue) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: empty queue, actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_issue = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk({31'b0, irq}, 0, "R1 irq in reset");
    chk(pin_oe, 0, "R1 oe in reset");
    rst = 1'b0;
    rd(8'h18, 32'hFFFF_FFFF, "R1 mask after reset");
    rd(8'h00, 32'h0, "R1 mode after reset");
    rd(8'h08, 32'h0, "R1 output data after reset");

    // R2 general output
    wr(8'h08, 32'h0000_00A5);
    wr(8'h04, 32'h0000_000F);
    idle(1);
    chk(pin_oe, 32'h0000_000F, "R2 oe general outputs");
    chk(pin_out, 32'h0000_00A5, "R2 output data");
    wr(8'h00, 32'h0000_0001);
    idle(1);
    chk(pin_oe, 32'h0000_000E, "R2 interrupt pin not driven");
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);

    // R3 input read, R10 no pending in general mode
    pin_in = 32'h1234_5678;
    idle(3);
    rd(8'h0C, 32'h1234_5678, "R3 input data");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h1234_5678, "R3 input write ignored");
    rd(8'h10, 32'h0, "R10 general mode no pending");
    pin_in = 32'h0;
    idle(3);

    // R11 readback and unmapped
    wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, 32'hDEAD_BEEF, "R11 polarity readback");
    rd(8'h30, 32'h0, "R11 unmapped reads zero");
    wr(8'h20, 32'h0);

    // R4 level mode on pin 4
    wr(8'h00, 32'h0000_0010);
    pin_in = 32'h0000_0010;
    idle(3);
    rd(8'h10, 32'h0000_0010, "R4 active high pending");
    wr(8'h14, 32'h0000_0010);
    rd(8'h10, 32'h0000_0010, "R4 clear does not remove level");
    idle(2);
    chk({31'b0, irq}, 0, "R9 masked pending no irq");
    wr(8'h1C, 32'h0000_0010);
    rd(8'h18, 32'hFFFF_FFEF, "R8 unmask one bit");
    chk({31'b0, irq}, 1, "R9 unmasked pending raises irq");
    pin_in = 32'h0;
    idle(4);
    rd(8'h10, 32'h0, "R4 level gone");
    chk({31'b0, irq}, 0, "R9 irq drops");
    wr(8'h20, 32'h0000_0010);
    idle(1);
    rd(8'h10, 32'h0000_0010, "R4 active low pending");
    wr(8'h1C, 32'h0);
    rd(8'h18, 32'hFFFF_FFEF, "R8 unmask zero no effect");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'hFFFF_FFEF, "R8 mask ones no effect");
    wr(8'h18, 32'hFFFF_FFEF);
    rd(8'h18, 32'hFFFF_FFFF, "R8 mask zero masks");
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h0);

    // R5 edge mode on pin 8
    wr(8'h24, 32'h0000_0100);
    wr(8'h00, 32'h0000_0100);
    pin_in = 32'h0000_0100;
    idle(4);
    rd(8'h10, 32'h0000_0100, "R5 rising edge flags");
    pin_in = 32'h0;
    idle(4);
    rd(8'h10, 32'h0000_0100, "R5 flag sticky");
    wr(8'h14, 32'hFFFF_FEFF);
    rd(8'h10, 32'h0000_0100, "R7 clear zero bit no effect");
    wr(8'h14, 32'h0000_0100);
    rd(8'h10, 32'h0, "R7 clear one bit");
    wr(8'h20, 32'h0000_0100);
    pin_in = 32'h0000_0100;
    idle(4);
    rd(8'h10, 32'h0, "R5 rising ignored when falling selected");
    pin_in = 32'h0;
    idle(4);
    rd(8'h10, 32'h0000_0100, "R5 falling edge flags");
    wr(8'h14, 32'h0000_0100);

    // R6 both edges, polarity still 1
    wr(8'h4C, 32'h0000_0100);
    pin_in = 32'h0000_0100;
    idle(4);
    rd(8'h10, 32'h0000_0100, "R6 rising with both edges");
    wr(8'h14, 32'h0000_0100);
    rd(8'h10, 32'h0, "R6 cleared");
    pin_in = 32'h0;
    idle(4);
    rd(8'h10, 32'h0000_0100, "R6 falling with both edges");

    // R7 edge in the same cycle as the clear
    @(negedge clk);
    pin_in = 32'h0000_0100;
    @(negedge clk);
    wr(8'h14, 32'h0000_0100);
    rd(8'h10, 32'h0000_0100, "R7 new edge wins over clear");
    wr(8'h1C, 32'h0000_0100);
    idle(1);
    chk({31'b0, irq}, 1, "R9 edge pending unmasked");
    wr(8'h14, 32'h0000_0100);
    idle(2);
    chk({31'b0, irq}, 0, "R9 irq low after clear");

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule